// File: doc/BRIEF.md
# Rotating Four-Way Arbiter with Priority Override

This block shares one resource among four requesters. It is clocked, and only one requester can hold the resource at a time. When the resource is free, the first request present is served on the following clock edge. When several requesters compete, access rotates in circular order. Each winner keeps its grant for a fixed number of cycles, so every requester is served in turn.

A configuration mask marks some requesters as urgent. When any marked requester is asking, only the marked requesters take part in the selection, and they rotate among themselves. A programmable wait count can make each chosen requester hold off for some cycles before its grant rises. A single down-counter times both the wait and the slice. A three-state controller (idle, waiting, granted) runs that counter.

The `busy` output is high whenever the controller is not idle. The grant vector is one-hot while a slice runs and all-zero otherwise.

Top module: `rrpa_top`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle, and `gnt` and `busy` are both zero while reset is held.
- R2: When the block is idle, `grant_dly` is 0 and some request is high, a grant is issued on the next rising clock edge.
- R3: While its request stays high, a grant lasts exactly `slice_len` cycles, with a value of 0 treated as 1. After it falls, `gnt` stays zero for at least one cycle before any other grant rises.
- R4: The search for a winner starts at the index one above the last granted requester, wrapping from 3 to 0. After reset it starts at index 0.
- R5: If any request whose bit in `prio` is 1 is present when a winner is chosen, the winner comes from those requesters only, in the rotating order of R4.
- R6: With `grant_dly` = d > 0, the grant rises d cycles later than under R2. During those cycles `gnt` stays zero and `busy` is high.
- R7: If the granted requester drops its request before its slice ends, the grant falls on the next edge. The search pointer then moves past that requester.
- R8: If the chosen requester drops its request while waiting, no grant is issued and the search pointer is left unchanged. A grant only rises for a requester whose request was high on the edge before.
- R9: `busy` is high while a grant is held or a wait is running, and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Request vector, bit i from requester i |
| prio | input | 4 | Urgent-requester mask, 1 marks urgent |
| slice_len | input | 8 | Grant length in cycles (0 acts as 1) |
| grant_dly | input | 8 | Wait cycles before a grant rises |
| gnt | output | 4 | One-hot grant vector |
| busy | output | 1 | High while waiting or granted |

## Verification
The bench builds the block with its default parameters: four requesters and 8-bit counters. Because the width is four, every wrap of the rotation pointer from index 3 back to 0 occurs within a few slices. The bench uses slice lengths of 0 to 5 and waits of 0 to 4. These short values keep each grant episode to a handful of cycles, so the expected order and length of every episode can be queued up front. That same range covers the zero-slice clamp, the zero-wait fast path, an abandoned wait and an early release.

// File: rtl/rrpa_pkg.sv
package rrpa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GRANT = 2'd2
  } arb_state_t;
endpackage

// File: rtl/rrpa_select.sv
module rrpa_select #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  prio,
  input  logic [IW-1:0] ptr,
  output logic          win_valid,
  output logic [IW-1:0] win_idx
);
  // first set bit of v, scanning upward from start with wrap
  function automatic logic [IW-1:0] rr_first(input logic [N-1:0] v,
                                             input logic [IW-1:0] start);
    logic [IW-1:0] pick;
    logic          found;
    int            j;
    pick  = start;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      j = (int'(start) + i) % N;
      if (!found && v[j]) begin
        pick  = IW'(j);
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  logic [N-1:0] urgent;
  logic [N-1:0] pool;

  always_comb begin
    urgent    = req & prio;
    pool      = (|urgent) ? urgent : req;
    win_valid = |req;
    win_idx   = rr_first(pool, ptr);
  end
endmodule

// File: rtl/rrpa_ctrl.sv
module rrpa_ctrl
  import rrpa_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [CW-1:0] slice_len,
  input  logic [CW-1:0] grant_dly,
  input  logic          win_valid,
  input  logic [IW-1:0] win_idx,
  output arb_state_t    state,
  output logic [IW-1:0] owner,
  output logic [IW-1:0] ptr,
  output logic          ev_start,
  output logic          ev_release
);
  logic [CW-1:0] cnt;
  logic          owner_req;
  logic          take;
  logic [CW-1:0] slice_m1;

  function automatic logic [CW-1:0] slice_load(input logic [CW-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  function automatic logic [IW-1:0] ptr_after(input logic [IW-1:0] idx);
    return (idx == IW'(N-1)) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    owner_req  = req[owner];
    slice_m1   = slice_load(slice_len);
    take       = (state == ST_IDLE) && win_valid;
    ev_start   = (take && grant_dly == '0) ||
                 (state == ST_WAIT && owner_req && cnt == '0);
    ev_release = (state == ST_GRANT) && (!owner_req || cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      owner <= '0;
      ptr   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          owner <= win_idx;
          if (grant_dly == '0) begin
            state <= ST_GRANT;
            cnt   <= slice_m1;
          end else begin
            state <= ST_WAIT;
            cnt   <= grant_dly - 1'b1;
          end
        end
        ST_WAIT: begin
          if (!owner_req) begin
            state <= ST_IDLE;
          end else if (ev_start) begin
            state <= ST_GRANT;
            cnt   <= slice_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GRANT: begin
          if (ev_release) begin
            state <= ST_IDLE;
            ptr   <= ptr_after(owner);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rrpa_top.sv
module rrpa_top
  import rrpa_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  prio,
  input  logic [CW-1:0] slice_len,
  input  logic [CW-1:0] grant_dly,
  output logic [N-1:0]  gnt,
  output logic          busy
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          win_valid;
  logic [IW-1:0] win_idx;
  logic [IW-1:0] owner;
  logic [IW-1:0] ptr;
  logic          ev_start;
  logic          ev_release;
  arb_state_t    state;

  rrpa_select #(.N(N), .IW(IW)) u_sel (
    .req(req), .prio(prio), .ptr(ptr),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  rrpa_ctrl #(.N(N), .IW(IW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req),
    .slice_len(slice_len), .grant_dly(grant_dly),
    .win_valid(win_valid), .win_idx(win_idx),
    .state(state), .owner(owner), .ptr(ptr),
    .ev_start(ev_start), .ev_release(ev_release)
  );

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gnt[g] = (state == ST_GRANT) && (owner == IW'(g));
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/rrpa_checker.sv
module rrpa_checker #(
  parameter int N  = 4,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic [N-1:0]  prio,
  input logic [CW-1:0] grant_dly,
  input logic [N-1:0]  gnt,
  input logic          busy
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R1
  AST_IDLE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|req) && grant_dly == '0) |=> (|gnt)); // R2
  AST_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) != '0 && gnt != '0) |-> gnt == $past(gnt)); // R3
  AST_PRIO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|(req & prio)) && grant_dly == '0) |=> (|(gnt & $past(prio)))); // R5
  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|req) && grant_dly != '0) |=> (gnt == '0 && busy)); // R6
  AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && (req & gnt) == '0) |=> gnt == '0); // R7
  AST_RISE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && $past(gnt) == '0) |-> (|($past(req) & gnt))); // R8
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> busy); // R9
endmodule

bind rrpa_top rrpa_checker #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .prio(prio),
  .grant_dly(grant_dly), .gnt(gnt), .busy(busy)
);

// File: tb/tb_rrpa_top.sv
`timescale 1ns/1ps
module tb_rrpa_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] prio = '0;
  logic [7:0] slice_len = 8'd1;
  logic [7:0] grant_dly = 8'd0;
  logic [3:0] gnt;
  logic       busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    q_id[$];
  int    q_len[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  rrpa_top dut (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio),
    .slice_len(slice_len), .grant_dly(grant_dly),
    .gnt(gnt), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_ep(input int id, input int len, input string tag);
    q_id.push_back(id);
    q_len.push_back(len);
    q_tag.push_back(tag);
  endtask

  function automatic int idx_of(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  // monitor: each finished grant episode is compared with the queue head
  logic [3:0] prev_g = '0;
  int         run = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_g = '0;
      run = 0;
    end else begin
      if ($countones(gnt) > 1) chk(0, "R1 onehot", $countones(gnt), 1);
      if (prev_g != '0 && gnt != prev_g) begin
        if (q_id.size() == 0) begin
          chk(0, "R4 unexpected episode", idx_of(prev_g), -1);
        end else begin
          chk(idx_of(prev_g) == q_id[0], {q_tag[0], " winner"}, idx_of(prev_g), q_id[0]);
          chk(run == q_len[0], {q_tag[0], " length"}, run, q_len[0]);
          void'(q_id.pop_front());
          void'(q_len.pop_front());
          void'(q_tag.pop_front());
        end
      end
      if (gnt != '0 && gnt == prev_g) run++;
      else if (gnt != '0) run = 1;
      else run = 0;
      prev_g = gnt;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = '0;
    prio = '0;
    wait_n(2);
    chk(gnt == '0, "R1 gnt in reset", gnt, 0);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    // R2 idle fast path, R3 slice length
    do_reset();
    slice_len = 8'd3; grant_dly = 8'd0;
    req = 4'b0010;
    expect_ep(1, 3, "R3");
    wait_n(1);
    chk(gnt == 4'b0010, "R2 grant next edge", gnt, 4'b0010);
    chk(busy == 1'b1, "R9 busy while granted", busy, 1);
    wait_n(3);
    chk(gnt == 4'b0000, "R3 grant falls after slice", gnt, 0);
    req = '0;
    wait_n(2);
    chk(busy == 1'b0, "R9 busy low when idle", busy, 0);

    // R4 full rotation from index 0
    do_reset();
    slice_len = 8'd2;
    req = 4'b1111;
    expect_ep(0, 2, "R4"); expect_ep(1, 2, "R4"); expect_ep(2, 2, "R4");
    expect_ep(3, 2, "R4"); expect_ep(0, 2, "R4");
    wait_n(15);
    req = '0;
    wait_n(2);

    // R4 search starts one past the last winner
    do_reset();
    slice_len = 8'd1;
    req = 4'b0100;
    expect_ep(2, 1, "R4");
    wait_n(2);
    req = '0;
    wait_n(1);
    req = 4'b0101;
    expect_ep(0, 1, "R4"); expect_ep(2, 1, "R4");
    wait_n(4);
    req = '0;
    wait_n(2);

    // R5 priority mask
    do_reset();
    slice_len = 8'd1;
    prio = 4'b0100;
    req = 4'b1111;
    expect_ep(2, 1, "R5"); expect_ep(2, 1, "R5"); expect_ep(2, 1, "R5");
    wait_n(6);
    req = '0;
    wait_n(1);
    prio = 4'b0110;
    req = 4'b1111;
    expect_ep(1, 1, "R5"); expect_ep(2, 1, "R5"); expect_ep(1, 1, "R5");
    wait_n(6);
    req = '0;
    prio = '0;
    wait_n(2);

    // R6 programmable wait
    do_reset();
    slice_len = 8'd2; grant_dly = 8'd3;
    req = 4'b1000;
    expect_ep(3, 2, "R6");
    for (int k = 0; k < 3; k++) begin
      wait_n(1);
      chk(gnt == 4'b0000, "R6 no grant during wait", gnt, 0);
      chk(busy == 1'b1, "R6 busy during wait", busy, 1);
    end
    wait_n(1);
    chk(gnt == 4'b1000, "R6 grant after wait", gnt, 4'b1000);
    wait_n(2);
    req = '0;
    wait_n(2);
    do_reset();
    slice_len = 8'd1; grant_dly = 8'd1;
    req = 4'b0011;
    expect_ep(0, 1, "R6"); expect_ep(1, 1, "R6"); expect_ep(0, 1, "R6");
    wait_n(9);
    req = '0;
    wait_n(2);

    // R7 early release and pointer advance
    do_reset();
    slice_len = 8'd5; grant_dly = 8'd0;
    req = 4'b0001;
    expect_ep(0, 2, "R7");
    wait_n(2);
    req = '0;
    slice_len = 8'd1;
    wait_n(1);
    chk(gnt == 4'b0000, "R7 grant falls on drop", gnt, 0);
    req = 4'b0011;
    expect_ep(1, 1, "R7"); expect_ep(0, 1, "R7");
    wait_n(4);
    req = '0;
    wait_n(2);

    // R8 request withdrawn while waiting
    do_reset();
    slice_len = 8'd1; grant_dly = 8'd4;
    req = 4'b0001;
    wait_n(2);
    req = '0;
    for (int k = 0; k < 4; k++) begin
      wait_n(1);
      chk(gnt == 4'b0000, "R8 no grant after withdraw", gnt, 0);
    end
    chk(busy == 1'b0, "R8 back to idle", busy, 0);
    req = 4'b0011;
    expect_ep(0, 1, "R8"); expect_ep(1, 1, "R8");
    wait_n(12);
    req = '0;
    wait_n(2);

    // R3 zero slice acts as one
    do_reset();
    slice_len = 8'd0; grant_dly = 8'd0;
    req = 4'b0010;
    expect_ep(1, 1, "R3");
    wait_n(2);
    req = '0;
    wait_n(3);

    chk(q_id.size() == 0, "R4 all expected episodes seen", q_id.size(), 0);
    finished = 1;
    report();
  end
endmodule